// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Shifter

This block moves one byte at a time over a three-wire synchronous link: a serial data input, a serial data output and a shift clock. The same 8-bit register is shifted out and filled from the input. The outgoing bit leaves from the most significant end, and each received bit enters at the least significant end. Software loads the register, sets a busy flag to start a transfer and reads the register back once the flag drops. As master, the block makes the shift clock from the system clock at one of four rates. As slave, it follows an external shift clock, which it first passes through a two-flop synchronizer.

The shift clock is low whenever no transfer is running. A phase select picks which clock edge samples the input and which edge updates the output. Software may clear the busy flag before the end of a transfer, which stops it after fewer than eight bits. A load made while the shift clock is high is refused and sets a sticky error flag.

Top module: `serial_shift_port`

## Requirements
- R1: After reset, busy, sk_out, so, rd_data, done_irq and load_err are all 0.
- R2: A busy_set pulse while cfg_en is 0 is ignored. Dropping cfg_en during a transfer ends it, clears busy and returns sk_out low.
- R3: In master mode (cfg_master=1), sk_out has a period of 2, 4, 8 or 16 clk cycles for cfg_rate values 0, 1, 2 and 3. Its first edge after busy rises is a rising edge, and it stays low whenever busy is 0.
- R4: Data leaves most significant bit first on so. Received si bits enter rd_data at bit 0, so after eight bits rd_data holds the received byte with the first received bit at bit 7.
- R5: In normal phase (cfg_alt_phase=0), si is sampled on the rising SK edge and so changes on the falling edge. A load puts load_data[7] on so at once.
- R6: In alternate phase (cfg_alt_phase=1), si is sampled on the falling SK edge and so changes on the rising edge.
- R7: busy clears by itself at the eighth falling SK edge, so that exactly eight SK pulses occur per transfer.
- R8: A busy_clr pulse stops a transfer at once and forces sk_out low. The bits shifted before the stop stay in rd_data.
- R9: When cfg_irq_en is 1, completing eight bits gives a one-cycle done_irq pulse. An aborted transfer gives no pulse, and neither does a transfer with cfg_irq_en at 0.
- R10: In slave mode (cfg_master=0), sk_out stays 0. The external sk_in passes through a two-flop synchronizer, and its synchronized edges drive the shifting with the phase rules of R5 and R6.
- R11: A load_en while the shift clock is high (sk_out in master mode, the synchronized sk_in in slave mode) leaves rd_data unchanged and sets load_err. load_err stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Block enable |
| cfg_master | input | 1 | 1 = master (internal SK), 0 = slave (external SK) |
| cfg_rate | input | 2 | Master SK rate select, period 2<<cfg_rate clocks |
| cfg_alt_phase | input | 1 | 1 = sample on falling, drive on rising |
| cfg_irq_en | input | 1 | Enables the completion pulse |
| busy_set | input | 1 | Pulse: start a transfer |
| busy_clr | input | 1 | Pulse: stop a transfer early |
| load_en | input | 1 | Pulse: load load_data into the shift register |
| load_data | input | 8 | Parallel load value |
| rd_data | output | 8 | Shift register contents |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle pulse on completion of eight bits |
| load_err | output | 1 | Sticky: load attempted while SK high |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| sk_in | input | 1 | External shift clock (slave mode) |
| sk_out | output | 1 | Generated shift clock (master mode) |

## Verification
The assertions check the following on every cycle: the shift clock stays low and steady outside a transfer, busy rises only after an enabled busy_set, busy falls when the block is disabled, the completion pulse appears only while enabled and idle, and a load while SK is high always leaves a sticky error. The bench scenarios alone show the data path: the bit order in both directions, the clock period at each rate, the edge pairing in each phase, the partial contents after an early stop, and slave shifting from a slow external clock.

// File: rtl/serial_shift_port.sv
module serial_shift_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_master,
  input  logic [1:0]   cfg_rate,
  input  logic         cfg_alt_phase,
  input  logic         cfg_irq_en,
  input  logic         busy_set,
  input  logic         busy_clr,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  output logic [W-1:0] rd_data,
  output logic         busy,
  output logic         done_irq,
  output logic         load_err,
  input  logic         si,
  output logic         so,
  input  logic         sk_in,
  output logic         sk_out
);
  localparam int CW = $clog2(W);

  logic [2:0]    sk_sync;
  logic [3:0]    div_cnt;
  logic          sk_q;
  logic [CW-1:0] bit_cnt;
  logic [W-1:0]  sr;
  logic          so_q;
  logic          irq_q;
  logic          err_q;
  logic          busy_q;

  wire [3:0] half     = 4'd1 << cfg_rate;
  wire       active   = busy_q & cfg_en;
  wire       m_tick   = active & cfg_master & (div_cnt == half - 4'd1);
  wire       ext_rise = sk_sync[1] & ~sk_sync[2];
  wire       ext_fall = ~sk_sync[1] & sk_sync[2];
  wire       rise_e   = cfg_master ? (m_tick & ~sk_q) : (active & ext_rise);
  wire       fall_e   = cfg_master ? (m_tick & sk_q)  : (active & ext_fall);
  wire       samp_e   = (cfg_alt_phase ? fall_e : rise_e) & ~busy_clr;
  wire       drv_e    = (cfg_alt_phase ? rise_e : fall_e) & ~busy_clr;
  wire       sk_level = cfg_master ? sk_q : sk_sync[1];
  wire       load_ok  = load_en & ~sk_level;
  wire       load_bad = load_en & sk_level;
  wire       last     = fall_e & ~busy_clr & (bit_cnt == CW'(W - 1));
  wire       start    = busy_set & cfg_en & ~busy_q & ~busy_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_sync <= '0;
      div_cnt <= '0;
      sk_q    <= 1'b0;
      bit_cnt <= '0;
      sr      <= '0;
      so_q    <= 1'b0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      sk_sync <= {sk_sync[1:0], sk_in};

      if (busy_clr || !cfg_en || last) busy_q <= 1'b0;
      else if (start)                  busy_q <= 1'b1;

      if (!active || !cfg_master || m_tick) div_cnt <= '0;
      else                                  div_cnt <= div_cnt + 4'd1;

      if (!active || busy_clr || last) sk_q <= 1'b0;
      else if (m_tick)                 sk_q <= ~sk_q;

      if (!active || busy_clr || last) bit_cnt <= '0;
      else if (fall_e)                 bit_cnt <= bit_cnt + 1'b1;

      if (load_ok)     sr <= load_data;
      else if (samp_e) sr <= {sr[W-2:0], si};

      if (load_ok)     so_q <= load_data[W-1];
      else if (start)  so_q <= sr[W-1];
      else if (drv_e)  so_q <= sr[W-1];

      irq_q <= last & cfg_irq_en;

      if (load_bad) err_q <= 1'b1;
    end
  end

  assign rd_data  = sr;
  assign busy     = busy_q;
  assign done_irq = irq_q;
  assign load_err = err_q;
  assign so       = so_q;
  assign sk_out   = sk_q;

  assert_sk_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sk_out);

  assert_sk_moves_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sk_out) |-> $past(busy));

  assert_busy_needs_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(busy_set && cfg_en));

  assert_disable_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !busy);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> ($past(cfg_irq_en) && !busy));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |=> load_err);

  assert_load_high_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && cfg_master && sk_out) |=> load_err);

  assert_slave_no_sk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && !busy) |=> !sk_out);
endmodule

// File: tb/serial_shift_port_bench.sv
module serial_shift_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0, cfg_master = 1'b0, cfg_alt_phase = 1'b0, cfg_irq_en = 1'b0;
  logic [1:0] cfg_rate = 2'd0;
  logic       busy_set = 1'b0, busy_clr = 1'b0, load_en = 1'b0;
  logic [7:0] load_data = 8'h00;
  logic [7:0] rd_data;
  logic       busy, done_irq, load_err, so, sk_out;
  logic       si = 1'b0, sk_in = 1'b0;

  int checks = 0;
  int errors = 0;
  int irqn = 0;
  bit done = 1'b0;

  serial_shift_port u_serial_shift_port (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
    .cfg_rate(cfg_rate), .cfg_alt_phase(cfg_alt_phase), .cfg_irq_en(cfg_irq_en),
    .busy_set(busy_set), .busy_clr(busy_clr), .load_en(load_en),
    .load_data(load_data), .rd_data(rd_data), .busy(busy), .done_irq(done_irq),
    .load_err(load_err), .si(si), .so(so), .sk_in(sk_in), .sk_out(sk_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int exp_period(input logic [1:0] r);
    return 2 << r;
  endfunction

  function automatic logic [7:0] partial(input logic [7:0] dut, input logic [7:0] per, input int n);
    logic [7:0] v = dut;
    for (int i = 0; i < n; i++) v = {v[6:0], per[7 - i]};
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (done_irq) irqn++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic do_load(input logic [7:0] v);
    load_data = v; load_en = 1'b1;
    tick(1);
    load_en = 1'b0;
  endtask

  task automatic master_xfer(input logic [1:0] rate, input logic alt, input logic ien,
                             input logic [7:0] tx, input logic [7:0] per, input int abort_at);
    int nr = 0, nf = 0, cyc = 0, last_rise = -1, tmo = 0;
    bit per_ok = 1'b1;
    logic prev = 1'b0;
    logic [7:0] cap = 8'h00;
    cfg_en = 1'b1; cfg_master = 1'b1; cfg_rate = rate; cfg_alt_phase = alt; cfg_irq_en = ien;
    irqn = 0;
    do_load(tx);
    chk("R5 so preset", so, tx[7]);
    si = alt ? 1'b0 : per[7];
    busy_set = 1'b1;
    tick(1);
    busy_set = 1'b0;
    while (busy && tmo < 600) begin
      tick(1);
      tmo++; cyc++;
      if (sk_out && !prev) begin
        nr++;
        if (last_rise >= 0 && (cyc - last_rise) != exp_period(rate)) per_ok = 1'b0;
        last_rise = cyc;
        if (!alt) cap = {cap[6:0], so};
        else if (nr <= 8) si = per[8 - nr];
        if (abort_at > 0 && nr == abort_at) begin
          busy_clr = 1'b1;
          tick(1);
          busy_clr = 1'b0;
          cyc++;
        end
      end else if (!sk_out && prev) begin
        nf++;
        if (alt) cap = {cap[6:0], so};
        else if (nf < 8) si = per[7 - nf];
      end
      prev = sk_out;
    end
    tick(2);
    chk("R3 sk low after", sk_out, 1'b0);
    if (abort_at > 0) begin
      chk("R8 busy stopped", busy, 1'b0);
      chk("R8 rising edges", nr, abort_at);
      chk("R8 partial rd_data", rd_data, partial(tx, per, abort_at));
      chk("R9 no irq on abort", irqn, 0);
    end else begin
      chk("R3 SK period", per_ok, 1'b1);
      chk("R7 eight pulses", nr, 8);
      chk("R7 busy cleared", busy, 1'b0);
      chk(alt ? "R6 R4 received" : "R5 R4 received", rd_data, per);
      chk(alt ? "R6 R4 sent" : "R5 R4 sent", cap, tx);
      chk("R9 irq count", irqn, ien ? 1 : 0);
    end
  endtask

  task automatic slave_xfer(input logic alt, input logic ien, input logic [7:0] tx, input logic [7:0] per);
    localparam int H = 6;
    logic [7:0] cap = 8'h00;
    cfg_en = 1'b1; cfg_master = 1'b0; cfg_alt_phase = alt; cfg_irq_en = ien;
    sk_in = 1'b0;
    irqn = 0;
    tick(4);
    do_load(tx);
    busy_set = 1'b1;
    tick(1);
    busy_set = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!alt) si = per[7 - i];
      tick(H);
      sk_in = 1'b1;
      if (alt) si = per[7 - i];
      tick(H);
      chk("R10 sk_out idle in slave", sk_out, 1'b0);
      cap = {cap[6:0], so};
      sk_in = 1'b0;
    end
    tick(8);
    chk("R10 busy cleared", busy, 1'b0);
    chk("R10 R4 received", rd_data, per);
    chk("R10 R4 sent", cap, tx);
    chk("R9 slave irq", irqn, ien ? 1 : 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] a, b;
    void'($urandom(32'd1234));
    do_reset();
    chk("R1 busy", busy, 0);
    chk("R1 sk_out", sk_out, 0);
    chk("R1 so", so, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 irq", done_irq, 0);
    chk("R1 load_err", load_err, 0);

    cfg_en = 1'b0; cfg_master = 1'b1;
    busy_set = 1'b1; tick(1); busy_set = 1'b0;
    tick(20);
    chk("R2 busy ignored while disabled", busy, 0);
    chk("R2 sk quiet while disabled", sk_out, 0);

    for (int r = 0; r < 4; r++) begin
      master_xfer(2'(r), 1'b0, 1'b1, 8'hA5, 8'h3C, 0);
      master_xfer(2'(r), 1'b1, 1'b0, 8'h81, 8'hE7, 0);
    end
    master_xfer(2'd2, 1'b0, 1'b1, 8'hF0, 8'h96, 3);
    master_xfer(2'd0, 1'b0, 1'b1, 8'h00, 8'hFF, 0);
    master_xfer(2'd1, 1'b1, 1'b1, 8'hFF, 8'h00, 0);

    cfg_en = 1'b1; cfg_master = 1'b1; cfg_rate = 2'd3;
    busy_set = 1'b1; tick(1); busy_set = 1'b0;
    tick(5);
    cfg_en = 1'b0;
    tick(2);
    chk("R2 disable aborts busy", busy, 0);
    chk("R2 disable forces sk low", sk_out, 0);

    for (int k = 0; k < 20; k++) begin
      a = 8'($urandom); b = 8'($urandom);
      master_xfer(2'($urandom), 1'($urandom), 1'($urandom), a, b, 0);
    end

    slave_xfer(1'b0, 1'b1, 8'hC3, 8'h5A);
    slave_xfer(1'b1, 1'b1, 8'h29, 8'hB4);
    for (int k = 0; k < 6; k++) begin
      a = 8'($urandom); b = 8'($urandom);
      slave_xfer(1'($urandom), 1'($urandom), a, b);
    end

    cfg_en = 1'b1; cfg_master = 1'b0;
    a = rd_data;
    sk_in = 1'b1;
    tick(4);
    do_load(8'h5A ^ a);
    tick(1);
    chk("R11 high load ignored", rd_data, a);
    chk("R11 load_err set", load_err, 1);
    sk_in = 1'b0;
    tick(4);
    do_load(8'h77);
    tick(3);
    chk("R11 low load accepted", rd_data, 8'h77);
    chk("R11 load_err sticky", load_err, 1);

    do_reset();
    chk("R1 load_err cleared by reset", load_err, 0);
    chk("R1 rd_data after reset", rd_data, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule